// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two N-bit integers over several clock cycles and returns the 2N-bit product as an upper word and a lower word. It uses a single accumulator register of 2N bits. At the start, the multiplier is placed in the low half and the high half is cleared. On every cycle the block looks at the accumulator's least significant bit. When that bit is 1, it adds the multiplicand into the high half. In the same cycle it shifts the whole register right by one, with the adder's carry moving into the top bit. After N such cycles the register holds the product.

A mode input chooses between unsigned and signed two's-complement operation. In signed mode the magnitudes are multiplied, and the full-width result is negated when the operand signs differ. The most negative operand is treated as the unsigned magnitude 2^(N-1). A caller pulses `start` while the unit is idle. It then waits for the one-cycle `done` pulse and reads `prod_hi` and `prod_lo`, which stay unchanged until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst` is high at a clock edge, the unit goes idle: `busy`=0, `done`=0, and `prod_hi` and `prod_lo` are both zero after that edge.
- R2: A clock edge with `start`=1 and `busy`=0 captures `op_a` (multiplicand), `op_b` (multiplier) and `is_signed`, and sets `busy` to 1 after that edge. Operand changes after the capture have no effect on the result.
- R3: Let the accepting edge be edge 0. The unit steps at edges 1 through N. After edge N, `busy` is 0 and `done` is 1 for exactly one cycle. The count does not depend on the operand values.
- R4: With `is_signed`=0, {`prod_hi`,`prod_lo`} equals the unsigned 2N-bit product. This includes cases where the high-half add carries out, such as all-ones times all-ones.
- R5: With `is_signed`=1, {`prod_hi`,`prod_lo`} equals the signed 2N-bit two's-complement product, negative whenever exactly one operand is negative and the other is nonzero.
- R6: In signed mode an operand equal to -2^(N-1) is taken as magnitude 2^(N-1). Examples: (-2^(N-1))×(-1) gives 2^(N-1), and (-2^(N-1))×(-2^(N-1)) gives 2^(2N-2).
- R7: A `start` pulse while `busy`=1 is ignored. The running multiply keeps its operands and its cycle count.
- R8: While `busy`=0, `prod_hi` and `prod_lo` keep their value until an edge that accepts a new start.
- R9: `prod_hi` carries bits 2N-1..N of the product and `prod_lo` carries bits N-1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiply; accepted only when idle |
| is_signed | input | 1 | 1 = signed two's-complement operands, 0 = unsigned |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| busy | output | 1 | High while a multiply is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| prod_hi | output | WIDTH | Upper half of the product |
| prod_lo | output | WIDTH | Lower half of the product |

## Verification
The product is tested with zero, one, all-ones and most-negative operands in both modes.

- All-ones times all-ones in unsigned mode separates a datapath that keeps the adder carry from one that drops it. Dropping the carry corrupts the upper word.
- Mixed-sign pairs and the most-negative cases separate correct sign handling from a missing or misplaced negation. They also catch a magnitude that overflows.
- Random operand pairs in each mode cover the general add-and-shift path.

Separate runs change the operands straight after capture and send a second start halfway through a multiply. These runs separate a design that latches its inputs and ignores a busy-time request from one that follows its live inputs or restarts.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } mul_phase_t;

endpackage

// File: rtl/mul_operand_prep.sv
module mul_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic             is_signed,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] mag_a,
    output logic [WIDTH-1:0] mag_b,
    output logic             neg
);
    localparam int MSB = WIDTH - 1;

    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg = is_signed & op_a[MSB];
        b_neg = is_signed & op_b[MSB];
        // The two's complement of the most negative value is that same bit
        // pattern, which read as unsigned is exactly 2^(WIDTH-1).
        mag_a = a_neg ? (~op_a + WIDTH'(1)) : op_a;
        mag_b = b_neg ? (~op_b + WIDTH'(1)) : op_b;
        neg   = a_neg ^ b_neg;
    end
endmodule

// File: rtl/mul_step.sv
module mul_step #(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] acc_in,
    input  logic [WIDTH-1:0]   mcand,
    output logic [2*WIDTH-1:0] acc_out
);
    logic [WIDTH:0] addend;
    logic [WIDTH:0] upper_sum;

    always_comb begin
        addend    = acc_in[0] ? {1'b0, mcand} : '0;
        upper_sum = {1'b0, acc_in[2*WIDTH-1:WIDTH]} + addend;
        // The carry bit ends up on top; the spent multiplier bit drops off.
        acc_out   = {upper_sum, acc_in[WIDTH-1:1]};
    end
endmodule

// File: rtl/mul_sign_fix.sv
module mul_sign_fix #(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH-1:0] prod_in,
    input  logic               neg,
    output logic [2*WIDTH-1:0] prod_out
);
    localparam int PW = 2 * WIDTH;

    always_comb begin
        prod_out = neg ? (~prod_in + PW'(1)) : prod_in;
    end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
    import mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] prod_hi,
    output logic [WIDTH-1:0] prod_lo
);
    localparam int                PW    = 2 * WIDTH;
    localparam int                CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(WIDTH - 1);

    typedef struct packed {
        mul_phase_t       ph;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] mcand;
        logic             neg;
        logic [PW-1:0]    acc;
        logic             done;
    } mul_regs_t;

    mul_regs_t r_d;
    mul_regs_t r_q;

    logic [WIDTH-1:0] mag_a;
    logic [WIDTH-1:0] mag_b;
    logic             neg_in;
    logic [PW-1:0]    stepped;
    logic [PW-1:0]    fixed;

    mul_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .is_signed (is_signed),
        .op_a      (op_a),
        .op_b      (op_b),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .neg       (neg_in)
    );

    mul_step #(.WIDTH(WIDTH)) u_step (
        .acc_in  (r_q.acc),
        .mcand   (r_q.mcand),
        .acc_out (stepped)
    );

    mul_sign_fix #(.WIDTH(WIDTH)) u_fix (
        .prod_in  (stepped),
        .neg      (r_q.neg),
        .prod_out (fixed)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (start) begin
                    r_d.ph    = PH_RUN;
                    r_d.cnt   = '0;
                    r_d.mcand = mag_a;
                    r_d.neg   = neg_in;
                    r_d.acc   = {{WIDTH{1'b0}}, mag_b};
                end
            end
            PH_RUN: begin
                r_d.cnt = r_q.cnt + CNT_W'(1);
                if (r_q.cnt == LAST) begin
                    r_d.ph   = PH_IDLE;
                    r_d.done = 1'b1;
                    r_d.acc  = fixed;
                end else begin
                    r_d.acc  = stepped;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = (r_q.ph == PH_RUN);
    assign done    = r_q.done;
    assign prod_hi = r_q.acc[PW-1:WIDTH];
    assign prod_lo = r_q.acc[WIDTH-1:0];

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && !done && prod_hi == '0 && prod_lo == '0));

    p_accept_start_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done));

    p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_run_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_busy_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start && r_q.cnt != LAST) |=>
            (busy && r_q.cnt == $past(r_q.cnt) + CNT_W'(1)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable({prod_hi, prod_lo}));
endmodule

// File: tb/tb_shift_add_mul.sv
`timescale 1ns/1ps
module tb_shift_add_mul;
    localparam int W  = 32;
    localparam int PW = 2 * W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] prod_hi;
    logic [W-1:0] prod_lo;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shift_add_mul #(.WIDTH(W)) dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .is_signed (is_signed),
        .op_a      (op_a),
        .op_b      (op_b),
        .busy      (busy),
        .done      (done),
        .prod_hi   (prod_hi),
        .prod_lo   (prod_lo)
    );

    function automatic logic [PW-1:0] ref_prod(input logic [W-1:0] a,
                                               input logic [W-1:0] b,
                                               input logic s);
        logic [PW-1:0] xa;
        logic [PW-1:0] xb;
        xa = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        xb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        return xa * xb;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Cycle-level behavioural model, built from the requirements.
    bit            m_busy = 1'b0;
    bit            m_done = 1'b0;
    int            m_cnt  = 0;
    logic [PW-1:0] m_pend = '0;
    logic [PW-1:0] m_prod = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0; m_prod <= '0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy && start) begin
                m_busy <= 1'b1; m_cnt <= 0;
                m_pend <= ref_prod(op_a, op_b, is_signed);
            end else if (m_busy) begin
                m_cnt <= m_cnt + 1;
                if (m_cnt == W - 1) begin
                    m_busy <= 1'b0; m_done <= 1'b1; m_prod <= m_pend;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(busy == m_busy, "R2 busy per cycle", PW'(busy), PW'(m_busy));
            check(done == m_done, "R3 done per cycle", PW'(done), PW'(m_done));
            if (!m_busy)
                check({prod_hi, prod_lo} == m_prod, "R8 idle product",
                      {prod_hi, prod_lo}, m_prod);
        end
    end

    // Run one multiply. With mid_start set, a conflicting start is sent mid-run.
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input string tag, input bit mid_start);
        logic [PW-1:0] exp;
        int n;
        exp = ref_prod(a, b, s);
        @(negedge clk);
        start = 1'b1; op_a = a; op_b = b; is_signed = s;
        @(negedge clk);
        start = 1'b0;
        op_a = $urandom; op_b = $urandom; is_signed = ~s;
        n = 1;
        while (!done && n < W + 10) begin
            if (mid_start && n == W / 2) start = 1'b1;
            if (mid_start && n == W / 2 + 1) start = 1'b0;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(n == W + 1, "R3 cycle count", PW'(n), PW'(W + 1));
        check({prod_hi, prod_lo} == exp, tag, {prod_hi, prod_lo}, exp);
        check(prod_hi == exp[PW-1:W], "R9 upper word", PW'(prod_hi), PW'(exp[PW-1:W]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [W-1:0] mn;
        logic [W-1:0] ones;
        mn = {1'b1, {(W-1){1'b0}}};
        ones = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done, "R1 reset flags", PW'({busy, done}), '0);
        check({prod_hi, prod_lo} == '0, "R1 reset product", {prod_hi, prod_lo}, '0);
        rst = 1'b0;

        run(W'(21), W'(5), 1'b0, "R4 small unsigned", 1'b0);
        run('0, ones, 1'b0, "R4 zero", 1'b0);
        run(W'(1), ones, 1'b0, "R4 one", 1'b0);
        run(ones, ones, 1'b0, "R4 all-ones carry", 1'b0);
        run(mn, mn, 1'b0, "R4 top bit unsigned", 1'b0);
        run(ones, W'(7), 1'b1, "R5 neg times pos", 1'b0);
        run(W'(7), ones, 1'b1, "R5 pos times neg", 1'b0);
        run(ones, ones, 1'b1, "R5 neg times neg", 1'b0);
        run('0, ones, 1'b1, "R5 zero signed", 1'b0);
        run(mn, ones, 1'b1, "R6 most-neg times -1", 1'b0);
        run(mn, mn, 1'b1, "R6 most-neg squared", 1'b0);
        run(mn, W'(1), 1'b1, "R6 most-neg times 1", 1'b0);
        run(W'(12345), W'(678), 1'b0, "R7 busy start ignored", 1'b1);
        run(mn, W'(3), 1'b1, "R7 busy start ignored signed", 1'b1);

        repeat (8) begin
            @(negedge clk);
            op_a = $urandom; op_b = $urandom;
        end
        check({prod_hi, prod_lo} == ref_prod(mn, W'(3), 1'b1), "R8 hold after done",
              {prod_hi, prod_lo}, ref_prod(mn, W'(3), 1'b1));

        for (int i = 0; i < 40; i++) begin
            run(W'($urandom), W'($urandom), 1'b0, "R4 random unsigned", 1'b0);
            run(W'($urandom), W'($urandom), 1'b1, "R5 random signed", 1'b0);
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && {prod_hi, prod_lo} == '0, "R1 reset after use",
              {prod_hi, prod_lo}, '0);
        repeat (2) @(negedge clk);
        report();
    end
endmodule